// File: doc/BRIEF.md
# Deferred ROM/RAM access buffer

This block sits beside a graphics coprocessor core and hides slow external memory behind two background buffers. Writing the ROM pointer starts a ROM read: a latency count is loaded and the ROM-busy flag is raised. When enough elapsed cycles have been reported, the byte at the captured bank and pointer is fetched over a byte bus and held in a ROM data register, and the busy flag drops. A RAM write is posted the same way: the bank, address and data byte are captured with a latency count, and the byte is written to external RAM once that count has run out.

Time is not counted by the block's own clock. The core reports elapsed cycles on an advance input, and each pending counter is reduced by that amount, stopping at zero. Any later access to the same side first drains its counter. A ROM sync forces the remaining ROM count to zero. A RAM read forces any pending RAM write out before the read itself is issued. All traffic leaves on one byte bus with a request/acknowledge handshake, and at most one access is made per clock.

Top module: `mem_defer_buf`

## Requirements
- R1: After reset both counters are zero, `rom_busy` is 0, `rom_data` is 0x00 and no bus request is made, even when cycles are advanced.
- R2: A pulse on `ptr_wr` captures `{rom_bank, ptr_data}` as the ROM address, loads the ROM counter with `rom_lat` and sets `rom_busy` from the next cycle.
- R3: An advance of N cycles lowers each nonzero counter by the smaller of N and its remaining count. The counter never wraps below zero. Each access is requested once, starting the cycle after its counter reaches zero.
- R4: A ROM fetch reads the address captured at the start (bank in bits 23:16, pointer in bits 15:0). In the cycle after the request is acknowledged, `rom_data` holds the returned byte and `rom_busy` is 0.
- R5: A pulse on `ram_post` captures a write of `ram_wdata` to RAM_BASE (0x700000) + (`ram_bank` << 16) + `ram_addr` with latency `ram_lat`. When the counter expires, the write is issued with `bus_we` = 1.
- R6: `rom_sync` drains the ROM counter, so a pending ROM fetch is requested in the next cycle. With nothing pending it causes no access.
- R7: `ram_rd` drains the RAM counter and queues a read of RAM_BASE + (`ram_bank` << 16) + `ram_rd_addr`. The read is issued only after any pending RAM write has been acknowledged. `ram_rd_valid` pulses with the byte in the cycle after the read is acknowledged.
- R8: At most one request is made per clock. When several accesses are ready and none is waiting for an acknowledge, the ROM fetch goes first, then the RAM write, then the RAM read.
- R9: A request that is not acknowledged stays on the bus with the same address, kind and data until it is acknowledged, even if a higher-priority access becomes ready.
- R10: A latency of zero makes the access ready at once, so its request appears in the cycle after the start.
- R11: A new start of the same kind (`ptr_wr` or `ram_post`) replaces a pending access of that kind and its count. The replaced access is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_valid | input | 1 | Elapsed-cycle report is valid this clock |
| adv_cycles | input | CNT_W | Number of elapsed cycles reported |
| rom_bank | input | BANK_W | ROM bank captured at a pointer write |
| ptr_wr | input | 1 | Pointer write; starts a ROM read |
| ptr_data | input | ADDR_W | New pointer value (ROM address low part) |
| rom_lat | input | CNT_W | ROM read latency in elapsed cycles |
| rom_sync | input | 1 | Drain the pending ROM countdown |
| ram_bank | input | BANK_W | RAM bank for a posted write or a read |
| ram_post | input | 1 | Post a RAM write |
| ram_addr | input | ADDR_W | Posted write address within the bank |
| ram_wdata | input | DATA_W | Posted write data |
| ram_lat | input | CNT_W | RAM write latency in elapsed cycles |
| ram_rd | input | 1 | Request a RAM read (drains pending write) |
| ram_rd_addr | input | ADDR_W | RAM read address within the bank |
| rom_busy | output | 1 | ROM read in progress |
| rom_data | output | DATA_W | Last fetched ROM byte |
| ram_rd_valid | output | 1 | RAM read result valid (one-cycle pulse) |
| ram_rd_data | output | DATA_W | RAM read result |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | BANK_W+ADDR_W | Bus byte address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Bus accepts the request this clock |

## Verification
The bench goes after advances larger than the remaining count. A counter that wraps instead of stopping at zero would never fire, or would fire a second time later. It also covers ROM and RAM expiring together and a RAM read issued behind a live write. Here a wrong arbiter would drive two requests at once, or read stale RAM before the write lands. With the acknowledge throttled, a ROM fetch becomes ready while a RAM write is still waiting. A design without grant holding would switch the address under a pending request. Zero latencies, replaced starts and syncs with nothing pending are also covered, because an off-by-one in expiry detection would drop, duplicate or invent bus accesses there.

// File: rtl/mem_defer_pkg.sv
package mem_defer_pkg;
    // Requesters on the shared byte bus, lowest index wins
    localparam int SRC_ROM = 0;
    localparam int SRC_WR  = 1;
    localparam int SRC_RD  = 2;
    localparam int NUM_SRC = 3;
endpackage

// File: rtl/mem_defer_countdown.sv
module mem_defer_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] adv_n,
    input  logic             drain,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q, left_v;

    always_comb begin
        left_v = cnt_q;
        if (adv) left_v = (adv_n >= cnt_q) ? '0 : cnt_q - adv_n;
        if (drain) left_v = '0;
        cnt_d  = left_v;
        expire = (cnt_q != '0) && (left_v == '0);
        if (load) begin
            cnt_d  = load_val;
            expire = (load_val == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: advancing never raises the count (no wrap below zero)
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && !drain) |=> (cnt_q <= $past(cnt_q)));
    // R1: an empty idle counter never reports expiry
    assert_quiet_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |-> !expire);
    // R6: a drain leaves nothing to count
    assert_drain_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/mem_defer_arb.sv
module mem_defer_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] hold,
    output logic [N-1:0] gnt
);
    logic [N-1:0] kept;
    logic         taken;

    always_comb begin
        kept  = hold & pend;
        gnt   = '0;
        taken = 1'b0;
        if (kept != '0) begin
            gnt = kept;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (pend[i] && !taken) begin
                    gnt[i] = 1'b1;
                    taken  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mem_defer_buf.sv
module mem_defer_buf
    import mem_defer_pkg::*;
#(
    parameter int          CNT_W    = 8,
    parameter int          BANK_W   = 8,
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int unsigned RAM_BASE = 32'h0070_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv_valid,
    input  logic [CNT_W-1:0]         adv_cycles,
    input  logic [BANK_W-1:0]        rom_bank,
    input  logic                     ptr_wr,
    input  logic [ADDR_W-1:0]        ptr_data,
    input  logic [CNT_W-1:0]         rom_lat,
    input  logic                     rom_sync,
    input  logic [BANK_W-1:0]        ram_bank,
    input  logic                     ram_post,
    input  logic [ADDR_W-1:0]        ram_addr,
    input  logic [DATA_W-1:0]        ram_wdata,
    input  logic [CNT_W-1:0]         ram_lat,
    input  logic                     ram_rd,
    input  logic [ADDR_W-1:0]        ram_rd_addr,
    output logic                     rom_busy,
    output logic [DATA_W-1:0]        rom_data,
    output logic                     ram_rd_valid,
    output logic [DATA_W-1:0]        ram_rd_data,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic [BANK_W+ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0]        bus_wdata,
    input  logic [DATA_W-1:0]        bus_rdata,
    input  logic                     bus_ack
);
    localparam int BUS_AW = BANK_W + ADDR_W;
    localparam logic [BUS_AW-1:0] BASE_A = BUS_AW'(RAM_BASE);

    typedef struct packed {
        logic                rom_fetch;
        logic                wr_pend;
        logic                rd_pend;
        logic                busy;
        logic [DATA_W-1:0]   rom_data;
        logic [BUS_AW-1:0]   rom_addr;
        logic [BUS_AW-1:0]   wr_addr;
        logic [DATA_W-1:0]   wr_data;
        logic [BUS_AW-1:0]   rd_addr;
        logic                rd_valid;
        logic [DATA_W-1:0]   rd_data;
        logic [NUM_SRC-1:0]  hold;
    } st_t;

    st_t st_d, st_q;
    logic rom_exp, ram_exp;
    logic [NUM_SRC-1:0] pend, gnt;

    mem_defer_countdown #(.CNT_W(CNT_W)) u_rom_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv_valid), .adv_n(adv_cycles),
        .drain(rom_sync), .load(ptr_wr), .load_val(rom_lat), .expire(rom_exp)
    );

    mem_defer_countdown #(.CNT_W(CNT_W)) u_ram_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv_valid), .adv_n(adv_cycles),
        .drain(ram_rd), .load(ram_post), .load_val(ram_lat), .expire(ram_exp)
    );

    always_comb begin
        pend          = '0;
        pend[SRC_ROM] = st_q.rom_fetch;
        pend[SRC_WR]  = st_q.wr_pend;
        pend[SRC_RD]  = st_q.rd_pend;
    end

    mem_defer_arb #(.N(NUM_SRC)) u_arb (.pend(pend), .hold(st_q.hold), .gnt(gnt));

    always_comb begin
        bus_req   = |gnt;
        bus_we    = gnt[SRC_WR];
        bus_wdata = st_q.wr_data;
        if (gnt[SRC_ROM])     bus_addr = st_q.rom_addr;
        else if (gnt[SRC_WR]) bus_addr = st_q.wr_addr;
        else                  bus_addr = st_q.rd_addr;
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.hold     = (bus_req && !bus_ack) ? gnt : '0;
        // completions
        if (gnt[SRC_ROM] && bus_ack) begin
            st_d.rom_data  = bus_rdata;
            st_d.busy      = 1'b0;
            st_d.rom_fetch = 1'b0;
        end
        if (gnt[SRC_WR] && bus_ack) st_d.wr_pend = 1'b0;
        if (gnt[SRC_RD] && bus_ack) begin
            st_d.rd_pend  = 1'b0;
            st_d.rd_valid = 1'b1;
            st_d.rd_data  = bus_rdata;
        end
        // ROM side
        if (ptr_wr) begin
            st_d.busy      = 1'b1;
            st_d.rom_addr  = {rom_bank, ptr_data};
            st_d.rom_fetch = rom_exp;
        end else if (rom_exp) begin
            st_d.rom_fetch = 1'b1;
        end
        // RAM side
        if (ram_post) begin
            st_d.wr_addr = BASE_A + {ram_bank, {ADDR_W{1'b0}}} + {{BANK_W{1'b0}}, ram_addr};
            st_d.wr_data = ram_wdata;
            st_d.wr_pend = ram_exp;
        end else if (ram_exp) begin
            st_d.wr_pend = 1'b1;
        end
        if (ram_rd) begin
            st_d.rd_pend = 1'b1;
            st_d.rd_addr = BASE_A + {ram_bank, {ADDR_W{1'b0}}} + {{BANK_W{1'b0}}, ram_rd_addr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rom_busy     = st_q.busy;
    assign rom_data     = st_q.rom_data;
    assign ram_rd_valid = st_q.rd_valid;
    assign ram_rd_data  = st_q.rd_data;

    // R8: a single requester owns the bus
    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R8: a ready ROM fetch wins when no grant is held
    assert_rom_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rom_fetch && st_q.hold == '0) |-> (bus_req && !bus_we && bus_addr == st_q.rom_addr));
    // R4: busy drops only after an acknowledged ROM fetch
    assert_busy_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_busy) |-> $past(bus_req && bus_ack && gnt[SRC_ROM]));
    // R9: an unacknowledged request is held unchanged
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !ptr_wr && !ram_post && !ram_rd)
        |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
    // R7: a read result follows an acknowledged RAM read
    assert_read_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_valid |-> $past(bus_req && bus_ack && gnt[SRC_RD]));
endmodule

// File: tb/mem_defer_buf_tb_top.sv
module mem_defer_buf_tb_top;
    localparam int CNT_W = 8, BANK_W = 8, ADDR_W = 16, DATA_W = 8, AW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              adv_valid = 0, ptr_wr = 0, rom_sync = 0, ram_post = 0, ram_rd = 0;
    logic [CNT_W-1:0]  adv_cycles = 0, rom_lat = 0, ram_lat = 0;
    logic [BANK_W-1:0] rom_bank = 0, ram_bank = 0;
    logic [ADDR_W-1:0] ptr_data = 0, ram_addr = 0, ram_rd_addr = 0;
    logic [DATA_W-1:0] ram_wdata = 0;
    logic              bus_ack = 1'b1;
    logic [DATA_W-1:0] bus_rdata;
    logic              rom_busy, ram_rd_valid, bus_req, bus_we;
    logic [DATA_W-1:0] rom_data, ram_rd_data, bus_wdata;
    logic [AW-1:0]     bus_addr;

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ (a[23:16] + 8'h3C);
    endfunction
    assign bus_rdata = mem_byte(bus_addr);

    mem_defer_buf dut_i (
        .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid), .adv_cycles(adv_cycles),
        .rom_bank(rom_bank), .ptr_wr(ptr_wr), .ptr_data(ptr_data), .rom_lat(rom_lat),
        .rom_sync(rom_sync), .ram_bank(ram_bank), .ram_post(ram_post), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_lat(ram_lat), .ram_rd(ram_rd), .ram_rd_addr(ram_rd_addr),
        .rom_busy(rom_busy), .rom_data(rom_data), .ram_rd_valid(ram_rd_valid),
        .ram_rd_data(ram_rd_data), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, ack_mode = 0;
    string tag = "R1";

    // behavioural reference state
    int            m_rc = 0, m_wc = 0, m_hold = 0;
    bit            m_rf = 0, m_wp = 0, m_rp = 0, m_busy = 0, m_rdv = 0;
    logic [7:0]    m_rdata = 0, m_rdd = 0, m_wdata = 0;
    logic [AW-1:0] m_raddr = 0, m_waddr = 0, m_rdaddr = 0;

    // 0 none, 1 ROM fetch, 2 RAM write, 3 RAM read
    function automatic int m_grant();
        bit held_live;
        held_live = (m_hold == 1 && m_rf) || (m_hold == 2 && m_wp) || (m_hold == 3 && m_rp);
        if (held_live) return m_hold;
        if (m_rf) return 1;
        if (m_wp) return 2;
        if (m_rp) return 3;
        return 0;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic m_tick();
        int g, old;
        bit acc;
        g   = m_grant();
        acc = (g != 0) && bus_ack;
        m_rdv = 0;
        if (acc && g == 1) begin m_rdata = mem_byte(m_raddr); m_busy = 0; m_rf = 0; end
        if (acc && g == 2) m_wp = 0;
        if (acc && g == 3) begin m_rp = 0; m_rdv = 1; m_rdd = mem_byte(m_rdaddr); end
        m_hold = (g != 0 && !bus_ack) ? g : 0;
        old = m_rc;
        if (adv_valid) m_rc = (int'(adv_cycles) >= m_rc) ? 0 : m_rc - int'(adv_cycles);
        if (rom_sync) m_rc = 0;
        if (ptr_wr) begin
            m_rc = int'(rom_lat); m_busy = 1; m_raddr = {rom_bank, ptr_data}; m_rf = (rom_lat == 0);
        end else if (old != 0 && m_rc == 0) m_rf = 1;
        old = m_wc;
        if (adv_valid) m_wc = (int'(adv_cycles) >= m_wc) ? 0 : m_wc - int'(adv_cycles);
        if (ram_rd) m_wc = 0;
        if (ram_post) begin
            m_wc = int'(ram_lat); m_wdata = ram_wdata;
            m_waddr = 24'h700000 + (AW'(ram_bank) << 16) + AW'(ram_addr);
            m_wp = (ram_lat == 0);
        end else if (old != 0 && m_wc == 0) m_wp = 1;
        if (ram_rd) begin
            m_rp = 1;
            m_rdaddr = 24'h700000 + (AW'(ram_bank) << 16) + AW'(ram_rd_addr);
        end
    endtask

    task automatic m_compare();
        int g;
        g = m_grant();
        chk("bus_req", 32'(bus_req), 32'(g != 0));
        if (g != 0) begin
            chk("bus_we", 32'(bus_we), 32'(g == 2));
            chk("bus_addr", 32'(bus_addr), (g == 1) ? 32'(m_raddr) : (g == 2) ? 32'(m_waddr) : 32'(m_rdaddr));
            if (g == 2) chk("bus_wdata", 32'(bus_wdata), 32'(m_wdata));
        end
        chk("rom_busy", 32'(rom_busy), 32'(m_busy));
        chk("rom_data", 32'(rom_data), 32'(m_rdata));
        chk("ram_rd_valid", 32'(ram_rd_valid), 32'(m_rdv));
        if (m_rdv) chk("ram_rd_data", 32'(ram_rd_data), 32'(m_rdd));
    endtask

    task automatic step();
        @(posedge clk);
        m_tick();
        cyc++;
        @(negedge clk);
        m_compare();
        adv_valid = 0; ptr_wr = 0; rom_sync = 0; ram_post = 0; ram_rd = 0;
        bus_ack = (ack_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic adv(input int n);
        adv_valid = 1; adv_cycles = CNT_W'(n); step();
    endtask

    task automatic rom_go(input logic [7:0] b, input logic [15:0] p, input int lat);
        rom_bank = b; ptr_data = p; rom_lat = CNT_W'(lat); ptr_wr = 1;
    endtask

    task automatic ram_go(input logic [7:0] b, input logic [15:0] a, input logic [7:0] d, input int lat);
        ram_bank = b; ram_addr = a; ram_wdata = d; ram_lat = CNT_W'(lat); ram_post = 1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        chk("reset rom_busy", 32'(rom_busy), 0);
        chk("reset rom_data", 32'(rom_data), 0);
        chk("reset bus_req", 32'(bus_req), 0);
        idle(2);
        adv(200);
        idle(2);

        tag = "R2";
        rom_go(8'h12, 16'h3456, 10); step();
        chk("busy after start", 32'(rom_busy), 1);
        tag = "R3";
        adv(3); adv(3); adv(3);
        chk("no request before zero", 32'(bus_req), 0);
        adv(9);
        chk("request after expiry", 32'(bus_req), 1);
        tag = "R4";
        step();
        chk("fetched byte", 32'(rom_data), 32'(mem_byte(24'h123456)));
        chk("busy cleared", 32'(rom_busy), 0);
        tag = "R3";
        adv(50); idle(2);

        tag = "R5";
        ram_go(8'h03, 16'h0100, 8'hA5, 5); step();
        adv(2); adv(2); adv(2);
        idle(2);

        tag = "R6";
        rom_go(8'h20, 16'h1111, 200); step();
        rom_sync = 1; step();
        chk("sync request", 32'(bus_req), 1);
        idle(2);
        rom_sync = 1; step();
        chk("empty sync quiet", 32'(bus_req), 0);
        idle(1);

        tag = "R7";
        ram_go(8'h01, 16'h0040, 8'h5C, 30); step();
        adv(4);
        ram_bank = 8'h02; ram_rd_addr = 16'h0200; ram_rd = 1; step();
        chk("drained write first", 32'(bus_we), 1);
        idle(4);
        ram_bank = 8'h05; ram_rd_addr = 16'h00FF; ram_rd = 1; step();
        idle(3);

        tag = "R8";
        rom_go(8'h44, 16'h0007, 6); ram_go(8'h00, 16'h0009, 8'h77, 6); step();
        adv(6);
        chk("rom wins", 32'(bus_we), 0);
        idle(3);

        tag = "R9";
        ack_mode = 1;
        ram_go(8'h06, 16'h0A0A, 8'h3E, 2); step();
        adv(2);
        rom_go(8'h09, 16'hBEEF, 1); step();
        adv(1);
        idle(10);
        ram_go(8'h07, 16'h0001, 8'h11, 0); step();
        ram_rd_addr = 16'h0002; ram_rd = 1; step();
        rom_go(8'h0A, 16'h0003, 0); step();
        idle(12);
        ack_mode = 0;
        idle(2);

        tag = "R10";
        rom_go(8'h7F, 16'hFFFF, 0); step();
        chk("immediate rom request", 32'(bus_req), 1);
        idle(1);
        ram_go(8'h0F, 16'hFFFF, 8'hC3, 0); step();
        chk("immediate ram write", 32'(bus_we), 1);
        idle(2);

        tag = "R11";
        rom_go(8'h01, 16'hAAAA, 5); step();
        adv(2);
        rom_go(8'h02, 16'hBBBB, 5); step();
        adv(3);
        chk("replaced not issued", 32'(bus_req), 0);
        adv(2);
        idle(2);
        ram_go(8'h03, 16'h1234, 8'h01, 4); step();
        adv(3);
        ram_go(8'h04, 16'h5678, 8'h02, 4); step();
        adv(1);
        chk("replaced write quiet", 32'(bus_req), 0);
        adv(3);
        idle(3);

        finish_run();
    end
endmodule